// File: doc/BRIEF.md
# Receive Byte Queue with Trigger Level and Idle Timeout

This block is the receive-side buffer of a 16550-style serial controller. Bytes arrive from a deserializer with a one-cycle valid strobe. A line break arrives as a separate one-cycle event. The host drains the queue one byte per read strobe. In queued mode the block holds up to `DEPTH` bytes in arrival order. In single mode it acts as one holding register.

A host control write sets three things: the mode, an optional flush, and the fill level that raises the trigger flag. A separate status-read strobe clears the sticky overrun and break flags. An idle detector counts externally supplied character-time ticks. It raises a timeout flag when bytes have waited too long with no receive or read. The deserializer, the transmit path and the interrupt arbitration that combines these flags all sit outside the block.

Top module: `rx_byte_queue`

## Requirements
- R1: After a synchronous active-low reset, the block is in single mode. `level`, `data_rdy`, `ovr_flag`, `brk_flag`, `trig_hit`, `idle_pend` and `fifo_on` are all 0, and `rd_data` is 0x00.
- R2: In queued mode, bytes are read out in arrival order. `rd_data` shows the oldest byte during the cycle `rd_en` is high. `level` reports the number of stored bytes one cycle after each push or pop.
- R3: In queued mode, a byte that arrives when `DEPTH` bytes are stored and no read is in that cycle is discarded. The stored bytes are kept, `level` stays at `DEPTH`, and `ovr_flag` is set.
- R4: In queued mode with `DEPTH` bytes stored, a read and an arriving byte in the same cycle accept the new byte. `level` stays at `DEPTH` and `ovr_flag` does not rise.
- R5: In single mode, a byte arriving while `data_rdy` is high (and no read is in that cycle) replaces the held byte and sets `ovr_flag`. A read returns the held byte and clears `data_rdy`. In single mode, `level` and `trig_hit` both equal `data_rdy`.
- R6: In queued mode, `trig_hit` is high when `level` is at least the trigger depth. The depth is chosen by `ctl_data[7:6]`: 00 selects 1, 01 selects 4, 10 selects 8 and 11 selects 14 (clamped to `DEPTH`).
- R7: A queued-mode read of an empty queue returns 0x00. `data_rdy` and `brk_flag` fall in the cycle after a read leaves the queue empty.
- R8: A break event stores a 0x00 byte and sets both `brk_flag` and `data_rdy`.
- R9: A control write flushes stored data, `data_rdy`, `brk_flag` and the timeout in two cases: when `ctl_data[1]` is 1, or when `ctl_data[0]` differs from the current mode. A write with `ctl_data[1]` = 0 and the same mode bit keeps the stored bytes. `ctl_data[0]` = 1 selects queued mode.
- R10: In queued mode, `idle_pend` rises after `IDLE_TICKS` `char_tick` pulses have been counted while data is stored with no push or read since the last one. Any read clears it. A push or read restarts the count.
- R11: A `stat_rd` pulse clears `ovr_flag` and `brk_flag`. A break event in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_byte | input | DW | Received byte |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` is valid |
| brk_evt | input | 1 | One-cycle line-break event |
| rd_en | input | 1 | Host read strobe, consumes one byte |
| rd_data | output | DW | Byte returned for the current read |
| stat_rd | input | 1 | Host status read, clears sticky flags |
| ctl_wr | input | 1 | Control write strobe |
| ctl_data | input | 8 | Control value: [0] mode, [1] flush, [7:6] trigger select |
| char_tick | input | 1 | One-cycle pulse per character time |
| data_rdy | output | 1 | At least one byte available |
| ovr_flag | output | 1 | Sticky overrun |
| brk_flag | output | 1 | Break received |
| level | output | $clog2(DEPTH+1) | Stored byte count |
| trig_hit | output | 1 | Fill level at or above trigger |
| idle_pend | output | 1 | Character timeout pending |
| fifo_on | output | 1 | Queued mode active |

## Verification
The bench uses the default parameters: `DEPTH` = 16, `IDLE_TICKS` = 4 and an 8-bit data width. A depth of 16 makes all four trigger selections reachable, including 14 without clamping. It also lets the bench fill the queue completely, so that both the discard-on-full path and the read-while-full path can be exercised. Four idle ticks keep the timeout windows short enough to test the restart on receive and on read at the exact boundary tick.

// File: rtl/rxq_pkg.sv
// Shared definitions for the receive byte queue.
// Assumes an 8-bit control word.
package rxq_pkg;

    localparam int CTL_EN_BIT    = 0;
    localparam int CTL_FLUSH_BIT = 1;

    typedef enum logic [1:0] {
        TRIG_ONE      = 2'd0,
        TRIG_FOUR     = 2'd1,
        TRIG_EIGHT    = 2'd2,
        TRIG_FOURTEEN = 2'd3
    } trig_sel_e;

    // Fill level selected by the trigger code, clamped to the queue depth.
    function automatic int trig_depth(trig_sel_e sel, int depth);
        int t;
        case (sel)
            TRIG_ONE:   t = 1;
            TRIG_FOUR:  t = 4;
            TRIG_EIGHT: t = 8;
            default:    t = 14;
        endcase
        return (t > depth) ? depth : t;
    endfunction

endpackage

// File: rtl/rxq_ring.sv
// Circular byte store with pointers and an occupancy count.
// Assumes DEPTH is a power of two, so the pointers wrap naturally.
// The caller never pushes when full unless it also pops in that cycle,
// and never pops when empty.
module rxq_ring #(
    parameter int DW    = 8,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic                         pop,
    input  logic [DW-1:0]                wdata,
    output logic [DW-1:0]                head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    // Entry storage: write the incoming byte at the tail.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Pointer and count update; flush empties the store.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign head = mem[rd_ptr];
    assign full = (count == CNT_W'(DEPTH));

endmodule

// File: rtl/rxq_idle.sv
// Character-timeout detector. It counts external per-character ticks while
// the queue is active and not empty, and raises pend after TICKS of them.
// Assumes TICKS >= 1.
module rxq_idle #(
    parameter int TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic restart,
    input  logic active,
    input  logic tick,
    output logic pend
);
    localparam int TW = (TICKS > 1) ? $clog2(TICKS) : 1;

    logic [TW-1:0] ticks_q;

    // Tick counter: restarts on activity, advances on each idle tick.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || clear || !active) begin
            ticks_q <= '0;
        end else if (tick && !pend) begin
            if (ticks_q == TW'(TICKS-1)) ticks_q <= '0;
            else                         ticks_q <= ticks_q + 1'b1;
        end
    end

    // Pending flag: set at the last tick, cleared by any host read or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pend <= 1'b0;
        end else if (active && !restart && tick && ticks_q == TW'(TICKS-1)) begin
            pend <= 1'b1;
        end
    end

endmodule

// File: rtl/rx_byte_queue.sv
// Receive byte queue for a 16550-style controller. It has a queued mode
// (DEPTH entries) and a single-register mode, a trigger level, sticky
// overrun and break flags, and an idle-timeout flag.
// Assumes: inputs are synchronous to clk; strobes last one cycle;
// a break and a byte in the same cycle store one 0x00 byte.
module rx_byte_queue #(
    parameter int DW         = 8,
    parameter int DEPTH      = 16,
    parameter int IDLE_TICKS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [DW-1:0]              rx_byte,
    input  logic                       rx_valid,
    input  logic                       brk_evt,
    input  logic                       rd_en,
    output logic [DW-1:0]              rd_data,
    input  logic                       stat_rd,
    input  logic                       ctl_wr,
    input  logic [7:0]                 ctl_data,
    input  logic                       char_tick,
    output logic                       data_rdy,
    output logic                       ovr_flag,
    output logic                       brk_flag,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       trig_hit,
    output logic                       idle_pend,
    output logic                       fifo_on
);
    import rxq_pkg::*;

    localparam int CNT_W = $clog2(DEPTH+1);

    trig_sel_e         trig_q;
    logic              fifo_q;
    logic [DW-1:0]     hold_q;
    logic              dr_q, ovr_q, brk_q;
    logic [DW-1:0]     head;
    logic [CNT_W-1:0]  cnt, cnt_after;
    logic              full;
    logic              flush, in_push, push_ok, pop, drop, single_ovr;
    logic [DW-1:0]     in_byte;
    logic              ctl_unused;

    assign ctl_unused = ^ctl_data[5:2];

    // Control decode: a flush is requested explicitly or by a mode change.
    assign flush   = ctl_wr && (ctl_data[CTL_FLUSH_BIT] || (ctl_data[CTL_EN_BIT] != fifo_q));
    assign in_push = rx_valid || brk_evt;
    assign in_byte = brk_evt ? '0 : rx_byte;

    // Queued-mode push/pop qualification, including read-while-full.
    assign pop        = fifo_q && rd_en && (cnt != '0) && !flush;
    assign push_ok    = fifo_q && in_push && !flush && (!full || pop);
    assign drop       = fifo_q && in_push && !flush && full && !pop;
    assign single_ovr = !fifo_q && in_push && !flush && dr_q && !rd_en;
    assign cnt_after  = cnt + CNT_W'(push_ok) - CNT_W'(pop);

    rxq_ring #(.DW(DW), .DEPTH(DEPTH)) u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (push_ok),
        .pop   (pop),
        .wdata (in_byte),
        .head  (head),
        .count (cnt),
        .full  (full)
    );

    rxq_idle #(.TICKS(IDLE_TICKS)) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (flush || (fifo_q && rd_en)),
        .restart (push_ok || pop),
        .active  (fifo_q && (cnt != '0)),
        .tick    (char_tick),
        .pend    (idle_pend)
    );

    // Control register: mode and trigger selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_q <= 1'b0;
            trig_q <= TRIG_ONE;
        end else if (ctl_wr) begin
            fifo_q <= ctl_data[CTL_EN_BIT];
            trig_q <= trig_sel_e'(ctl_data[7:6]);
        end
    end

    // Single-mode holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (!fifo_q && in_push && !flush) begin
            hold_q <= in_byte;
        end
    end

    // Data-ready: follows occupancy in queued mode, set/clear in single mode.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            dr_q <= 1'b0;
        end else if (fifo_q) begin
            dr_q <= (cnt_after != '0);
        end else if (in_push) begin
            dr_q <= 1'b1;
        end else if (rd_en) begin
            dr_q <= 1'b0;
        end
    end

    // Overrun: sticky until a status read; a new overrun wins over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
        end else if (drop || single_ovr) begin
            ovr_q <= 1'b1;
        end else if (stat_rd) begin
            ovr_q <= 1'b0;
        end
    end

    // Break flag: set by a break event; cleared by flush, status read or draining.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            brk_q <= 1'b0;
        end else if (brk_evt) begin
            brk_q <= 1'b1;
        end else if (stat_rd) begin
            brk_q <= 1'b0;
        end else if (fifo_q ? (cnt_after == '0) : rd_en) begin
            brk_q <= 1'b0;
        end
    end

    // Output mapping per mode.
    always_comb begin
        if (fifo_q) begin
            rd_data  = (cnt != '0) ? head : '0;
            level    = cnt;
            trig_hit = (int'(cnt) >= trig_depth(trig_q, DEPTH));
        end else begin
            rd_data  = hold_q;
            level    = CNT_W'(dr_q);
            trig_hit = dr_q;
        end
    end

    assign data_rdy = dr_q;
    assign ovr_flag = ovr_q;
    assign brk_flag = brk_q;
    assign fifo_on  = fifo_q;

endmodule

// File: rtl/rxq_checker.sv
// Temporal checks on the receive byte queue's ports, bound to every instance.
module rxq_checker #(
    parameter int DW    = 8,
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       rx_valid,
    input logic                       brk_evt,
    input logic                       rd_en,
    input logic [DW-1:0]              rd_data,
    input logic                       ctl_wr,
    input logic [7:0]                 ctl_data,
    input logic                       data_rdy,
    input logic                       ovr_flag,
    input logic                       brk_flag,
    input logic [$clog2(DEPTH+1)-1:0] level,
    input logic                       idle_pend,
    input logic                       fifo_on
);
    localparam int CNT_W = $clog2(DEPTH+1);

    p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(level) <= DEPTH);

    p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_on && level == CNT_W'(DEPTH) && (rx_valid || brk_evt) && !rd_en && !ctl_wr
        |=> level == CNT_W'(DEPTH) && ovr_flag);

    p_full_rw_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_on && level == CNT_W'(DEPTH) && rx_valid && rd_en && !ctl_wr && !ovr_flag
        |=> level == CNT_W'(DEPTH) && !ovr_flag);

    p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_on && level == '0 && rd_en |-> rd_data == '0);

    p_break_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        brk_evt && !ctl_wr |=> brk_flag && data_rdy);

    p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && ctl_data[1] |=> level == '0 && !data_rdy && !brk_flag && !idle_pend);

    p_read_clears_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_on && rd_en |=> !idle_pend);

endmodule

bind rx_byte_queue rxq_checker #(.DW(DW), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .brk_evt   (brk_evt),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .ctl_wr    (ctl_wr),
    .ctl_data  (ctl_data),
    .data_rdy  (data_rdy),
    .ovr_flag  (ovr_flag),
    .brk_flag  (brk_flag),
    .level     (level),
    .idle_pend (idle_pend),
    .fifo_on   (fifo_on)
);

// File: tb/sim_rx_byte_queue.sv
// Scoreboard bench: the driver tasks queue the expected bytes and a
// negedge monitor compares every read against them.
module sim_rx_byte_queue;
    localparam int DW = 8;
    localparam int DEPTH = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DW-1:0] rx_byte = '0;
    logic rx_valid = 1'b0, brk_evt = 1'b0, rd_en = 1'b0, stat_rd = 1'b0;
    logic ctl_wr = 1'b0, char_tick = 1'b0;
    logic [7:0] ctl_data = '0;
    logic [DW-1:0] rd_data;
    logic data_rdy, ovr_flag, brk_flag, trig_hit, idle_pend, fifo_on;
    logic [$clog2(DEPTH+1)-1:0] level;

    int n_chk = 0;
    int n_err = 0;
    logic [DW-1:0] exp_q [$];
    bit m_fifo = 1'b0;
    string mon_tag = "R2";

    always #5 clk = ~clk;

    rx_byte_queue #(.DW(DW), .DEPTH(DEPTH), .IDLE_TICKS(4)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .brk_evt(brk_evt), .rd_en(rd_en), .rd_data(rd_data), .stat_rd(stat_rd),
        .ctl_wr(ctl_wr), .ctl_data(ctl_data), .char_tick(char_tick),
        .data_rdy(data_rdy), .ovr_flag(ovr_flag), .brk_flag(brk_flag),
        .level(level), .trig_hit(trig_hit), .idle_pend(idle_pend), .fifo_on(fifo_on)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Start a cycle: just after the edge, drop all strobes.
    task automatic go();
        @(posedge clk); #1;
        rx_valid = 0; brk_evt = 0; rd_en = 0; stat_rd = 0; ctl_wr = 0; char_tick = 0;
    endtask

    // One idle cycle, then land mid-cycle with registered results visible.
    task automatic settle();
        go();
        @(negedge clk);
    endtask

    task automatic model_push(input logic [DW-1:0] b);
        if (m_fifo) begin
            if (exp_q.size() < DEPTH) exp_q.push_back(b);
        end else begin
            exp_q.delete();
            exp_q.push_back(b);
        end
    endtask

    task automatic send(input logic [DW-1:0] b);
        go(); rx_byte = b; rx_valid = 1; model_push(b);
    endtask

    task automatic brk();
        go(); brk_evt = 1; model_push('0);
    endtask

    task automatic rd();
        go(); rd_en = 1;
    endtask

    task automatic rw(input logic [DW-1:0] b);
        go(); rd_en = 1; rx_valid = 1; rx_byte = b; exp_q.push_back(b);
    endtask

    task automatic ctl(input logic [7:0] v);
        go(); ctl_wr = 1; ctl_data = v;
        if (v[1] || (v[0] != m_fifo)) exp_q.delete();
        m_fifo = v[0];
    endtask

    task automatic tick();
        go(); char_tick = 1;
    endtask

    task automatic stat();
        go(); stat_rd = 1;
    endtask

    // Monitor: every read is compared with the oldest expected byte (0x00 if none).
    always @(negedge clk) begin
        if (rst_n && rd_en) begin
            logic [DW-1:0] e;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : '0;
            chk({mon_tag, " read data"}, 32'(rd_data), 32'(e));
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_err++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 level", 32'(level), 0);
        chk("R1 data_rdy", 32'(data_rdy), 0);
        chk("R1 ovr", 32'(ovr_flag), 0);
        chk("R1 brk", 32'(brk_flag), 0);
        chk("R1 trig", 32'(trig_hit), 0);
        chk("R1 idle", 32'(idle_pend), 0);
        chk("R1 fifo_on", 32'(fifo_on), 0);
        chk("R1 rd_data", 32'(rd_data), 0);

        // R5 single mode: overwrite and overrun
        mon_tag = "R5";
        send(8'hA5); settle();
        chk("R5 data_rdy", 32'(data_rdy), 1);
        chk("R5 level", 32'(level), 1);
        chk("R5 trig", 32'(trig_hit), 1);
        send(8'h3C); settle();
        chk("R5 ovr", 32'(ovr_flag), 1);
        rd(); settle();
        chk("R5 data_rdy after read", 32'(data_rdy), 0);
        stat(); settle();
        chk("R11 ovr cleared", 32'(ovr_flag), 0);

        // R2/R3 queued mode fill and overrun
        mon_tag = "R2";
        ctl(8'h01); settle();
        chk("R9 fifo_on", 32'(fifo_on), 1);
        chk("R9 level after enable", 32'(level), 0);
        for (int i = 0; i < DEPTH; i++) send(8'(8'h10 + i));
        settle();
        chk("R2 level full", 32'(level), DEPTH);
        chk("R2 data_rdy", 32'(data_rdy), 1);
        chk("R3 no ovr yet", 32'(ovr_flag), 0);
        send(8'hEE); settle();
        chk("R3 level kept", 32'(level), DEPTH);
        chk("R3 ovr", 32'(ovr_flag), 1);
        stat(); settle();
        chk("R11 ovr cleared", 32'(ovr_flag), 0);
        mon_tag = "R4";
        rw(8'h77); settle();
        chk("R4 level", 32'(level), DEPTH);
        chk("R4 no ovr", 32'(ovr_flag), 0);
        mon_tag = "R2";
        for (int i = 0; i < DEPTH; i++) rd();
        settle();
        chk("R7 level empty", 32'(level), 0);
        chk("R7 data_rdy", 32'(data_rdy), 0);
        mon_tag = "R7";
        rd(); settle();

        // R6 trigger levels, R9 non-flushing writes
        mon_tag = "R2";
        ctl(8'h41);
        for (int i = 0; i < 3; i++) send(8'(8'h20 + i));
        settle();
        chk("R6 trig at 3 of 4", 32'(trig_hit), 0);
        send(8'h23); settle();
        chk("R6 trig at 4", 32'(trig_hit), 1);
        ctl(8'h81); settle();
        chk("R9 no flush", 32'(level), 4);
        chk("R6 trig at 4 of 8", 32'(trig_hit), 0);
        for (int i = 0; i < 4; i++) send(8'(8'h24 + i));
        settle();
        chk("R6 trig at 8", 32'(trig_hit), 1);
        ctl(8'hC1);
        for (int i = 0; i < 5; i++) send(8'(8'h28 + i));
        settle();
        chk("R6 trig at 13 of 14", 32'(trig_hit), 0);
        send(8'h2D); settle();
        chk("R6 trig at 14", 32'(trig_hit), 1);
        ctl(8'hC3); settle();
        chk("R9 flush level", 32'(level), 0);
        chk("R9 flush data_rdy", 32'(data_rdy), 0);

        // R8 break
        ctl(8'h01);
        send(8'h55); brk(); settle();
        chk("R8 level", 32'(level), 2);
        chk("R8 brk", 32'(brk_flag), 1);
        chk("R8 data_rdy", 32'(data_rdy), 1);
        rd(); settle();
        chk("R8 brk held", 32'(brk_flag), 1);
        mon_tag = "R8";
        rd(); settle();
        chk("R7 brk cleared on empty", 32'(brk_flag), 0);
        chk("R7 data_rdy cleared", 32'(data_rdy), 0);
        brk(); stat(); settle();
        chk("R11 brk cleared", 32'(brk_flag), 0);
        chk("R11 level", 32'(level), 1);
        rd(); settle();

        // R10 idle timeout
        mon_tag = "R10";
        send(8'h61);
        tick(); tick(); tick(); settle();
        chk("R10 no timeout at 3", 32'(idle_pend), 0);
        tick(); settle();
        chk("R10 timeout at 4", 32'(idle_pend), 1);
        send(8'h62); rd(); settle();
        chk("R10 read clears", 32'(idle_pend), 0);
        tick(); tick(); send(8'h63);
        tick(); tick(); tick(); settle();
        chk("R10 restart on receive", 32'(idle_pend), 0);
        tick(); settle();
        chk("R10 timeout after restart", 32'(idle_pend), 1);
        rd(); rd(); settle();
        chk("R10 cleared", 32'(idle_pend), 0);
        repeat (5) tick();
        settle();
        chk("R10 empty no timeout", 32'(idle_pend), 0);

        // R9 flush on mode change
        send(8'h71); ctl(8'h00); settle();
        chk("R9 mode flush level", 32'(level), 0);
        chk("R9 mode flush data_rdy", 32'(data_rdy), 0);
        chk("R9 fifo_on off", 32'(fifo_on), 0);

        finish_run();
    end

endmodule